// File: doc/BRIEF.md
# Four-Rail Power Sequencer

This block brings four supply rails up and down in a fixed order and tells a downstream controller when power can be trusted. The rails are a 1.15 V core rail, a 1.8 V I/O rail, a 1.21 V auxiliary rail and a 3.3 V I/O rail. The regulators and their threshold comparators are outside the block. Each comparator is modelled as a digital flag, and each regulator is driven by one enable bit. Rail index encoding on every rail vector: bit 0 core 1.15 V, bit 1 I/O 1.8 V, bit 2 auxiliary 1.21 V, bit 3 I/O 3.3 V.

Two signals go to the downstream controller:
- `pwr_good_o` is the power-good indication. It falls early, ahead of any rail going away.
- `pwr_sense_o` is the power-on-sense reset. It is held around the power-good edges with guaranteed intervals.

A high level on `pwr_req_i` starts power-up. A falling edge on `pwr_req_i` starts power-down. Every interval is a cycle count derived from the clock-frequency parameter `CLK_KHZ`: a time in ms becomes `CLK_KHZ*ms` cycles, and a time in µs becomes `ceil(CLK_KHZ*us/1000)` cycles. All asynchronous inputs pass through two-flop synchronizers.

Top module: `psq_rail_seq`

## Requirements
- R1: On power-up the core enable (bit 0) is set first. The 1.8 V enable (bit 1) is set only after the core rail reports 80 %. The 1.21 V enable (bit 2) is set only after the 1.8 V rail reports 80 %.
- R2: The 3.3 V enable (bit 3) is set between 10 ms and 50 ms after the core enable is set.
- R3: If the rails do not all report 80 % within 100 ms of the core enable, `fault_o` is set and the power-down sequence runs. `fault_o` is cleared at the next power-up start.
- R4: On power-down the 1.21 V enable is cleared first, together with the 3.3 V enable. The 1.8 V enable is cleared only after the 1.21 V rail reports below 20 % (`aux_low_i`).
- R5: The core enable is cleared last, and only after the 1.8 V and 3.3 V rails both report below 10 % (`rail_low_i` bit 0 for 1.8 V, bit 1 for 3.3 V).
- R6: `pwr_good_o` is low for at least 500 µs before any rail enable is cleared.
- R7: `pwr_sense_o` stays high for at least 500 µs after `pwr_good_o` falls, and then falls.
- R8: Once `pwr_sense_o` falls, it stays low for at least 100 ms before it rises again.
- R9: `pwr_sense_o` rises only when all four enables are set, all four rails report 80 % and `refclk_ok_i` is high. `pwr_good_o` rises the cycle after `pwr_sense_o`.
- R10: If `refclk_ok_i` drops while powered, `pwr_good_o` drops while `pwr_sense_o` stays high. It returns once the clock is stable again, after no less than 4 µs. If the loss lasts beyond 1000 µs, the power-down sequence runs instead.
- R11: A falling edge of `pwr_req_i` clears `pwr_good_o` three clock edges after the input changes, well within 10 ms. A new power-up starts only after `pwr_req_i` has been low and is high again.
- R12: While `rst_ni` is low all enables, `pwr_good_o`, `pwr_sense_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_req_i | input | 1 | Power-on request, asynchronous |
| refclk_ok_i | input | 1 | Reference clock stable, asynchronous |
| rail_up_i | input | 4 | Per-rail at-or-above-80 % flags |
| aux_low_i | input | 1 | 1.21 V rail below 20 % |
| rail_low_i | input | 2 | Below 10 %: bit 0 1.8 V, bit 1 3.3 V |
| rail_en_o | output | 4 | Per-rail regulator enables |
| pwr_good_o | output | 1 | Power-good to downstream controller |
| pwr_sense_o | output | 1 | Power-on-sense reset to downstream controller |
| fault_o | output | 1 | Start-up timeout fault |

## Verification
Any input change reaches the outputs on the third rising edge after it is driven: two synchronizer stages, then the registered state update. The bench drives inputs and samples outputs on falling edges. The exact request-to-power-good latency is therefore checked at the first, second and third falling edge after the drive.

Timed windows are checked as bounds on cycles counted between output events:
- the 3.3 V enable delay,
- the early-warning and hold gaps,
- the lockout time,
- the length of each power-good drop.

The bounds are computed in the bench from the millisecond and microsecond figures. The exact count is checked only for the start-up timeout, within a four-cycle allowance.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int NRAIL = 4;
  localparam int RAIL_CORE = 0;
  localparam int RAIL_IO = 1;
  localparam int RAIL_AUX = 2;
  localparam int RAIL_HV = 3;

  typedef enum logic [3:0] {
    ST_OFF, ST_RAMP, ST_WCLK, ST_POS, ST_ON, ST_BLIP, ST_WARN, ST_DN_AUX, ST_DN_IO
  } psq_state_e;

  function automatic int unsigned cyc_ms(int unsigned khz, int unsigned ms);
    return khz * ms;
  endfunction

  function automatic int unsigned cyc_us(int unsigned khz, int unsigned us);
    return (khz * us + 999) / 1000;
  endfunction
endpackage

// File: rtl/psq_sync.sv
module psq_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/psq_timer.sv
module psq_timer #(
  parameter int W        = 8,
  parameter bit RST_FULL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= RST_FULL ? '1 : '0;
    else if (clr_i)         cnt_o <= '0;
    else if (cnt_o != '1)   cnt_o <= cnt_o + 1'b1;  // saturate
  end

  AST_TMR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> cnt_o == '0);  // R3
endmodule

// File: rtl/psq_rail_seq.sv
module psq_rail_seq
  import psq_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 100000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_req_i,
  input  logic       refclk_ok_i,
  input  logic [3:0] rail_up_i,
  input  logic       aux_low_i,
  input  logic [1:0] rail_low_i,
  output logic [3:0] rail_en_o,
  output logic       pwr_good_o,
  output logic       pwr_sense_o,
  output logic       fault_o
);
  localparam int unsigned T_ALL_I  = cyc_ms(CLK_KHZ, 100);
  localparam int          TW       = $clog2(T_ALL_I + 2);
  localparam int unsigned EW_I     = cyc_us(CLK_KHZ, 500);
  localparam int unsigned PH_I     = cyc_us(CLK_KHZ, 500);
  localparam logic [TW-1:0] T_HV_ON    = TW'(cyc_ms(CLK_KHZ, 10));
  localparam logic [TW-1:0] T_HV_LATE  = TW'(cyc_ms(CLK_KHZ, 50));
  localparam logic [TW-1:0] T_ALL      = TW'(T_ALL_I);
  localparam logic [TW-1:0] T_LOCK     = TW'(cyc_ms(CLK_KHZ, 100));
  localparam logic [TW-1:0] T_EW       = TW'(EW_I);
  localparam logic [TW-1:0] T_PH       = TW'(PH_I);
  localparam logic [TW-1:0] T_WARN     = TW'((EW_I > PH_I) ? EW_I : PH_I);
  localparam logic [TW-1:0] T_BLIP_MIN = TW'(cyc_us(CLK_KHZ, 4));
  localparam logic [TW-1:0] T_BLIP_MAX = TW'(cyc_us(CLK_KHZ, 1000));
  localparam int SW = 9;

  // synchronized inputs
  logic [SW-1:0] sync_q;
  logic          req_s, clk_s, aux_lo_s;
  logic [3:0]    up_s;
  logic [1:0]    lo10_s;

  psq_sync #(.W(SW)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pwr_req_i, refclk_ok_i, rail_up_i, aux_low_i, rail_low_i}),
    .q_o   (sync_q)
  );
  assign {req_s, clk_s, up_s, aux_lo_s, lo10_s} = sync_q;

  psq_state_e  st_q, st_n;
  logic [3:0]  en_q, en_n;
  logic        pg_q, pg_n, pos_q, pos_n, flt_q, flt_n;
  logic        armed_q, start;
  logic [TW-1:0] t_cnt, lk_cnt;
  logic        all_up, lk_done;

  // state timer: restarts on every state change
  psq_timer #(.W(TW), .RST_FULL(1'b0)) i_seq_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_n != st_q),
    .cnt_o (t_cnt)
  );

  // power-on-sense low-time lockout; reset counts as already elapsed
  psq_timer #(.W(TW), .RST_FULL(1'b1)) i_lock_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (pos_q),
    .cnt_o (lk_cnt)
  );

  assign all_up  = (&en_q) && (&up_s);
  assign lk_done = lk_cnt >= T_LOCK;
  assign start   = (st_q == ST_OFF) && req_s && armed_q;

  always_comb begin
    st_n  = st_q;
    en_n  = en_q;
    pg_n  = pg_q;
    pos_n = pos_q;
    flt_n = flt_q;
    unique case (st_q)
      ST_OFF: if (start) begin
        en_n  = 4'b0001;
        flt_n = 1'b0;
        st_n  = ST_RAMP;
      end
      ST_RAMP: begin
        if (!req_s) st_n = ST_WARN;
        else if (all_up) st_n = ST_WCLK;
        else if (t_cnt >= T_ALL) begin
          flt_n = 1'b1;
          st_n  = ST_WARN;
        end else begin
          if (up_s[RAIL_CORE] && en_q[RAIL_CORE]) en_n[RAIL_IO] = 1'b1;
          if (up_s[RAIL_IO] && en_q[RAIL_IO])     en_n[RAIL_AUX] = 1'b1;
          if (t_cnt >= T_HV_ON)                   en_n[RAIL_HV] = 1'b1;
        end
      end
      ST_WCLK: begin
        if (!req_s) st_n = ST_WARN;
        else if (clk_s && lk_done) begin
          pos_n = 1'b1;
          st_n  = ST_POS;
        end
      end
      ST_POS: begin
        if (!req_s) st_n = ST_WARN;
        else begin
          pg_n = 1'b1;
          st_n = ST_ON;
        end
      end
      ST_ON: begin
        if (!req_s) begin
          pg_n = 1'b0;
          st_n = ST_WARN;
        end else if (!clk_s) begin
          pg_n = 1'b0;
          st_n = ST_BLIP;
        end
      end
      ST_BLIP: begin
        if (!req_s || t_cnt >= T_BLIP_MAX) st_n = ST_WARN;
        else if (clk_s && t_cnt >= T_BLIP_MIN) begin
          pg_n = 1'b1;
          st_n = ST_ON;
        end
      end
      ST_WARN: if (t_cnt >= T_WARN) begin
        pos_n          = 1'b0;
        en_n[RAIL_AUX] = 1'b0;
        en_n[RAIL_HV]  = 1'b0;
        st_n           = ST_DN_AUX;
      end
      ST_DN_AUX: if (aux_lo_s) begin
        en_n[RAIL_IO] = 1'b0;
        st_n          = ST_DN_IO;
      end
      ST_DN_IO: if (&lo10_s) begin
        en_n[RAIL_CORE] = 1'b0;
        st_n            = ST_OFF;
      end
      default: begin
        en_n  = '0;
        pg_n  = 1'b0;
        pos_n = 1'b0;
        st_n  = ST_OFF;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_OFF;
      en_q    <= '0;
      pg_q    <= 1'b0;
      pos_q   <= 1'b0;
      flt_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      en_q  <= en_n;
      pg_q  <= pg_n;
      pos_q <= pos_n;
      flt_q <= flt_n;
      if (!req_s)     armed_q <= 1'b1;
      else if (start) armed_q <= 1'b0;
    end
  end

  assign rail_en_o   = en_q;
  assign pwr_good_o  = pg_q;
  assign pwr_sense_o = pos_q;
  assign fault_o     = flt_q;

  // cycles power-good has been low, for interval checks
  logic [TW-1:0] pg_low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pg_low_cnt <= '0;
    else if (pg_q)               pg_low_cnt <= '0;
    else if (pg_low_cnt != '1)   pg_low_cnt <= pg_low_cnt + 1'b1;
  end

  AST_IO_AFTER_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q[RAIL_IO]) |-> en_q[RAIL_CORE] && $past(up_s[RAIL_CORE]));  // R1
  AST_AUX_AFTER_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q[RAIL_AUX]) |-> en_q[RAIL_IO] && $past(up_s[RAIL_IO]));  // R1
  AST_HV_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q[RAIL_HV]) |-> $past(t_cnt) >= T_HV_ON);  // R2
  AST_HV_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q[RAIL_HV]) |-> $past(t_cnt) <= T_HV_LATE);  // R2
  AST_IO_OFF_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q[RAIL_IO]) |-> !en_q[RAIL_AUX] && $past(aux_lo_s));  // R4
  AST_CORE_OFF_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q[RAIL_CORE]) |-> !en_q[RAIL_IO] && !en_q[RAIL_HV] && $past(&lo10_s));  // R5
  AST_EARLY_WARN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(en_q) & ~en_q)) |-> !pg_q && $past(pg_low_cnt) >= T_EW);  // R6
  AST_SENSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pos_q) |-> $past(pg_low_cnt) >= T_PH);  // R7
  AST_SENSE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pos_q) |-> $past(lk_cnt) >= T_LOCK);  // R8
  AST_SENSE_RAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pos_q) |-> (&en_q) && $past(clk_s));  // R9
  AST_PG_MIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_q) |-> pos_q && $past(pg_low_cnt) >= T_BLIP_MIN);  // R10
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_s) |=> !pg_q);  // R11
endmodule

// File: tb/test_psq_rail_seq.sv
module test_psq_rail_seq;
  localparam int KHZ = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       req = 1'b0, rclk = 1'b0;
  logic [3:0] up = '0;
  logic       aux_lo = 1'b1;
  logic [1:0] lo10 = 2'b11;
  logic [3:0] en;
  logic       pg, pos, flt;

  psq_rail_seq #(.CLK_KHZ(KHZ)) i_psq_rail_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwr_req_i(req), .refclk_ok_i(rclk),
    .rail_up_i(up), .aux_low_i(aux_lo), .rail_low_i(lo10),
    .rail_en_o(en), .pwr_good_o(pg), .pwr_sense_o(pos), .fault_o(flt)
  );

  function automatic int ms_c(int ms); return KHZ * ms; endfunction
  function automatic int us_c(int us); return (KHZ * us + 999) / 1000; endfunction

  int n_chk = 0, n_fail = 0;
  task automatic chk(bit ok, string r, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // rail plant: level 0..100 per rail
  int lvl[4];
  int rate[4];
  int cyc = 0, t_core = 0, t_pg_fall = -1000000, t_pos_fall = -1000000;
  logic [3:0] en_p = '0;
  logic pg_p = 0, pos_p = 0, blip = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (en[1] && !en_p[1]) chk(en[0] && lvl[0] >= 80, "R1 io enable", lvl[0], 80);
      if (en[2] && !en_p[2]) chk(en[1] && lvl[1] >= 80, "R1 aux enable", lvl[1], 80);
      if (en[0] && !en_p[0]) t_core = cyc;
      if (en[3] && !en_p[3])
        chk(cyc - t_core >= ms_c(10) && cyc - t_core <= ms_c(50), "R2 hv delay", cyc - t_core, ms_c(10));
      if (|(en_p & ~en))
        chk(!pg && cyc - t_pg_fall >= us_c(500), "R6 early warning", cyc - t_pg_fall, us_c(500));
      if (!en[1] && en_p[1]) chk(!en[2] && lvl[2] < 20, "R4 io disable", lvl[2], 19);
      if (!en[0] && en_p[0])
        chk(en == 4'b0000 && lvl[1] < 10 && lvl[3] < 10, "R5 core disable", int'(en), 0);
      if (!pg && pg_p) begin
        t_pg_fall = cyc;
        blip = pos;
      end
      if (!pos && pos_p) begin
        chk(cyc - t_pg_fall >= us_c(500), "R7 sense hold", cyc - t_pg_fall, us_c(500));
        t_pos_fall = cyc;
        blip = 0;
      end
      if (pos && !pos_p) begin
        chk(cyc - t_pos_fall >= ms_c(100), "R8 sense lockout", cyc - t_pos_fall, ms_c(100));
        chk(rclk && en == 4'hF && lvl[0] >= 80 && lvl[1] >= 80 && lvl[2] >= 80 && lvl[3] >= 80,
            "R9 sense rise", int'(en), 15);
      end
      if (pg && !pg_p) begin
        chk(pos && pos_p, "R9 pg after sense", int'(pos_p), 1);
        if (blip)
          chk(cyc - t_pg_fall >= us_c(4) && cyc - t_pg_fall <= us_c(1000), "R10 pg drop length",
              cyc - t_pg_fall, us_c(4));
        blip = 0;
      end
      for (int k = 0; k < 4; k++) begin
        if (en[k]) lvl[k] = (lvl[k] + rate[k] > 100) ? 100 : lvl[k] + rate[k];
        else       lvl[k] = (lvl[k] - 3 < 0) ? 0 : lvl[k] - 3;
        up[k] = lvl[k] >= 80;
      end
      aux_lo  = lvl[2] < 20;
      lo10[0] = lvl[1] < 10;
      lo10[1] = lvl[3] < 10;
      en_p  = en;
      pg_p  = pg;
      pos_p = pos;
    end
  end

  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > 190000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 190000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic set_rates();
    for (int k = 0; k < 4; k++) rate[k] = 1 + int'($urandom % 6);
  endtask

  task automatic wait_on(int lim);
    for (int i = 0; i < lim && !pg; i++) @(negedge clk);
  endtask

  task automatic wait_off(int lim);
    for (int i = 0; i < lim && en != 4'b0; i++) @(negedge clk);
  endtask

  task automatic power_up(string r);
    req = 1'b1;
    rclk = 1'b1;
    wait_on(20000);
    chk(pg && pos && en == 4'hF && !flt, r, int'(en), 15);
  endtask

  task automatic power_down(string r);
    req = 1'b0;
    wait_off(3000);
    repeat (4) @(negedge clk);
    chk(en == 4'b0 && !pos && !pg, r, int'(en), 0);
  endtask

  initial begin
    int unsigned seed;
    int d;
    seed = $urandom(32'd4242);
    for (int k = 0; k < 4; k++) lvl[k] = 0;
    set_rates();
    repeat (5) @(negedge clk);
    chk(en == 4'b0 && !pg && !pos && !flt, "R12 reset outputs", int'({en, pg, pos, flt}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(en == 4'b0 && !pg && !pos && !flt, "R12 after release", int'({en, pg, pos, flt}), 0);

    // need a low phase before the first start (R11)
    power_up("R9 first power-up");
    // exact request-drop latency
    req = 1'b0;
    @(negedge clk); chk(pg, "R11 pg edge1", pg, 1);
    @(negedge clk); chk(pg, "R11 pg edge2", pg, 1);
    @(negedge clk); chk(!pg, "R11 pg edge3", pg, 0);
    power_down("R4 R5 normal power-down");

    // start-up timeout with stuck aux rail
    set_rates();
    rate[2] = 0;
    req = 1'b1;
    rclk = 1'b1;
    for (int i = 0; i < 3000 && !en[0]; i++) @(negedge clk);
    d = 0;
    for (int i = 0; i < 15000 && !flt; i++) begin @(negedge clk); d++; end
    chk(flt && d >= ms_c(100) && d <= ms_c(100) + 4, "R3 timeout fault", d, ms_c(100) + 1);
    wait_off(3000);
    repeat (500) @(negedge clk);
    chk(en == 4'b0 && !pos && flt, "R11 no restart without low", int'(en), 0);
    req = 1'b0;
    repeat (10) @(negedge clk);

    set_rates();
    power_up("R3 fault cleared on restart");
    chk(!flt, "R3 fault clear", flt, 0);

    // short clock loss
    rclk = 1'b0;
    repeat (20) @(negedge clk);
    rclk = 1'b1;
    repeat (12) @(negedge clk);
    chk(pg && pos, "R10 short loss recovers", int'({pg, pos}), 3);
    // single-cycle glitch
    rclk = 1'b0;
    @(negedge clk);
    rclk = 1'b1;
    repeat (12) @(negedge clk);
    chk(pg && pos, "R10 glitch recovers", int'({pg, pos}), 3);
    // long loss -> power-down
    rclk = 1'b0;
    repeat (us_c(1000) + 20) @(negedge clk);
    chk(!pg && pos, "R10 long loss pg low sense high", int'({pg, pos}), 1);
    wait_off(3000);
    repeat (4) @(negedge clk);
    chk(en == 4'b0 && !pos && !flt, "R10 long loss power-down", int'(en), 0);
    rclk = 1'b1;
    repeat (200) @(negedge clk);
    chk(en == 4'b0, "R11 held request no restart", int'(en), 0);
    req = 1'b0;
    repeat (10) @(negedge clk);

    // random power cycles
    for (int it = 0; it < 4; it++) begin
      set_rates();
      if ($urandom % 3 == 0) begin
        req = 1'b1;
        rclk = 1'b1;
        repeat (1 + int'($urandom % 300)) @(negedge clk);
        power_down("R11 abort during ramp");
        chk(!flt, "R3 no fault on abort", flt, 0);
        repeat (5) @(negedge clk);
      end
      power_up("R9 random power-up");
      repeat (50 + int'($urandom % 400)) @(negedge clk);
      if ($urandom % 2 == 0) begin
        rclk = 1'b0;
        repeat (1 + int'($urandom % 60)) @(negedge clk);
        rclk = 1'b1;
        repeat (10) @(negedge clk);
        chk(pg && pos, "R10 random loss recovers", int'({pg, pos}), 3);
      end
      power_down("R5 random power-down");
      repeat (5 + int'($urandom % 20)) @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule